// File: doc/BRIEF.md
# Byte-Wide Programmable Device Configuration Master

This block configures a downstream programmable device through an eight-bit parallel slave port. A start pulse launches either a load or a readback of a given number of bytes. In a load, the block pulses the device's configuration reset and waits for the device to leave its initialisation phase. It then raises write enable and select, and accepts bytes one at a time from an upstream valid/ready stream. Each byte is placed on the outgoing data bus and transferred by a rising edge of the configuration clock. While the device reports a stall after an edge, the same byte stays on the bus and further clock pulses are issued.

After the last byte, select is dropped before write enable. The block then keeps pulsing the configuration clock until the device reports that configuration is complete. Every wait is bounded by a cycle-count timeout. An expired timeout sets a sticky flag and returns all control lines to their inactive levels.

In a readback, select is raised together with the configuration clock. For each byte the clock goes low and then high, and the incoming data bus is sampled one cycle after the rising edge. The result is offered on a downstream valid/ready stream, and clocking halts while a captured byte is still unconsumed. The readback ends by dropping select and giving one further full clock pulse.

Top module: `pconf_master`

## Requirements
- R1: After reset, cfg_reset_o, sel_o, wen_o and cfg_clk_o are 0, timeout_o is 0 and idle_o is 1. Every control output is active high, and its inactive level is 0.
- R2: A load start (mode_rd=0) raises cfg_reset_o for exactly one cycle. While tgt_initing_i or tgt_stall_i is high the block then waits, and wen_o rises only after both are low.
- R3: wen_o rises first, sel_o rises one cycle later and cfg_clk_o rises one cycle after that. No byte is accepted before this.
- R4: In a load, each byte is accepted through in_valid/in_ready while cfg_clk_o is high. It appears on cfg_wdata in the next cycle with cfg_clk_o low, and cfg_clk_o rises in the following cycle to transfer it. Bytes arrive at the target in stream order, and exactly byte_count bytes are taken.
- R5: If tgt_stall_i is high in the cycle after a rising edge, cfg_wdata keeps the same byte and cfg_clk_o makes another low-high pulse. This repeats until a rising edge is followed by tgt_stall_i low.
- R6: After the last byte, sel_o falls first and wen_o falls exactly one cycle later.
- R7: With sel_o and wen_o low, cfg_clk_o keeps pulsing until tgt_ready_i is seen high after a rising edge. The block then returns to idle with cfg_clk_o low and timeout_o low.
- R8: A wait for the initialisation condition to clear, for a stall to end or for completion that lasts TMO_CYC cycles sets timeout_o. At the same time it drops every control output to 0 and returns to idle. timeout_o stays set until the next start pulse clears it.
- R9: A readback start (mode_rd=1) raises sel_o and cfg_clk_o in the same cycle. wen_o and cfg_reset_o stay 0 for the whole readback.
- R10: In readback, each byte takes one low-high pulse of cfg_clk_o. cfg_rdata is sampled one cycle after the rising edge and offered on out_data with out_valid, and exactly byte_count bytes are produced in order.
- R11: While out_valid is high and out_ready is low, out_valid and out_data hold, and no further readback clock pulse starts.
- R12: At the end of a readback, sel_o falls and then exactly one more low-high pulse of cfg_clk_o follows before idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle launch pulse, taken when idle |
| mode_rd | input | 1 | 0 = load, 1 = readback; sampled with start |
| byte_count | input | CNT_W | Number of bytes to move; sampled with start |
| in_data | input | 8 | Upstream load byte |
| in_valid | input | 1 | Upstream byte is valid |
| in_ready | output | 1 | Block accepts the upstream byte this cycle |
| out_data | output | 8 | Captured readback byte |
| out_valid | output | 1 | Readback byte is valid |
| out_ready | input | 1 | Downstream accepts the readback byte |
| cfg_reset_o | output | 1 | Configuration reset request to the target |
| sel_o | output | 1 | Target select |
| wen_o | output | 1 | Target write enable |
| cfg_clk_o | output | 1 | Configuration clock to the target |
| cfg_wdata | output | 8 | Byte driven to the target |
| cfg_rdata | input | 8 | Byte returned by the target |
| tgt_initing_i | input | 1 | Target still initialising |
| tgt_stall_i | input | 1 | Target cannot take the current byte |
| tgt_ready_i | input | 1 | Target reports configuration complete |
| idle_o | output | 1 | Block is idle and can take a start |
| timeout_o | output | 1 | Sticky: the last operation timed out |

## Verification
The assertions assume that the upstream side holds in_data steady while in_valid waits for in_ready. They also assume that start is pulsed only while idle_o is high and that the target raises tgt_stall_i only in response to a clock edge during a load. The bench plays the target as a reactive model that changes tgt_stall_i, tgt_ready_i and cfg_rdata only at the edges it observes, and it issues start only after idle. out_ready is free to toggle in any cycle. The bench drives it both constantly high and in an irregular pattern, so that the hold rule and the pause in clocking are exercised under backpressure.

// File: rtl/pconf_pkg.sv
package pconf_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_PGM,
        ST_INITW,
        ST_WEN,
        ST_SEL,
        ST_FETCH,
        ST_LO,
        ST_RISE,
        ST_RELSEL,
        ST_DCHK,
        ST_DLO,
        ST_RCHK,
        ST_RLO,
        ST_RSMP,
        ST_RREL,
        ST_RPHI,
        ST_RFIN
    } state_e;

    typedef struct packed {
        state_e              st;
        logic                pgm;
        logic                sel;
        logic                wen;
        logic                ck;
        logic [BYTE_W-1:0]   wdat;
        logic [BYTE_W-1:0]   rdat;
        logic                rvld;
        logic                tmo;
        logic                rd;
    } ctl_t;

endpackage

// File: rtl/pconf_tmo.sv
module pconf_tmo #(
    parameter int LIMIT = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run ? cnt_q + W'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == W'(LIMIT - 1));

    AST_TMO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0)                                         // R8
        else $error("wait counter did not restart");
endmodule

// File: rtl/pconf_cnt.sv
module pconf_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load)                rem_d = load_val;
        else if (dec && rem_q != '0) rem_d = rem_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    assign zero = (rem_q == '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec && !load |-> rem_q != '0)                                 // R4
        else $error("byte counter stepped below zero");
endmodule

// File: rtl/pconf_master.sv
module pconf_master
    import pconf_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int TMO_CYC = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_rd,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [7:0]        out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              cfg_reset_o,
    output logic              sel_o,
    output logic              wen_o,
    output logic              cfg_clk_o,
    output logic [7:0]        cfg_wdata,
    input  logic [7:0]        cfg_rdata,
    input  logic              tgt_initing_i,
    input  logic              tgt_stall_i,
    input  logic              tgt_ready_i,
    output logic              idle_o,
    output logic              timeout_o
);
    ctl_t q, n;
    logic run, expired, rem_load, rem_dec, rem_zero;

    pconf_tmo #(.LIMIT(TMO_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .run(run), .expired(expired)
    );

    pconf_cnt #(.CW(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(rem_load), .load_val(byte_count),
        .dec(rem_dec), .zero(rem_zero)
    );

    assign in_ready = (q.st == ST_FETCH) && !rem_zero;

    always_comb begin
        n        = q;
        run      = 1'b0;
        rem_load = 1'b0;
        rem_dec  = 1'b0;
        if (q.rvld && out_ready) n.rvld = 1'b0;
        case (q.st)
            ST_IDLE: if (start) begin
                n.tmo    = 1'b0;
                n.rd     = mode_rd;
                rem_load = 1'b1;
                if (mode_rd) begin
                    n.sel = 1'b1;
                    n.ck  = 1'b1;
                    n.st  = ST_RCHK;
                end else begin
                    n.pgm = 1'b1;
                    n.st  = ST_PGM;
                end
            end
            ST_PGM: begin
                n.pgm = 1'b0;
                n.st  = ST_INITW;
            end
            ST_INITW: begin
                run = 1'b1;
                if (!tgt_initing_i && !tgt_stall_i) begin
                    n.wen = 1'b1;
                    n.st  = ST_WEN;
                end
            end
            ST_WEN: begin
                n.sel = 1'b1;
                n.st  = ST_SEL;
            end
            ST_SEL: begin
                n.ck = 1'b1;
                n.st = ST_FETCH;
            end
            ST_FETCH: begin
                if (rem_zero) begin
                    n.sel = 1'b0;
                    n.st  = ST_RELSEL;
                end else if (in_valid) begin
                    n.wdat = in_data;
                    n.ck   = 1'b0;
                    n.st   = ST_LO;
                end
            end
            ST_LO: begin
                run  = 1'b1;
                n.ck = 1'b1;
                n.st = ST_RISE;
            end
            ST_RISE: begin
                run = 1'b1;
                if (tgt_stall_i) begin
                    n.ck = 1'b0;
                    n.st = ST_LO;
                end else begin
                    rem_dec = 1'b1;
                    n.st    = ST_FETCH;
                end
            end
            ST_RELSEL: begin
                n.wen = 1'b0;
                n.st  = ST_DCHK;
            end
            ST_DCHK: begin
                run  = 1'b1;
                n.ck = 1'b0;
                n.st = tgt_ready_i ? ST_IDLE : ST_DLO;
            end
            ST_DLO: begin
                run  = 1'b1;
                n.ck = 1'b1;
                n.st = ST_DCHK;
            end
            ST_RCHK: begin
                if (rem_zero) begin
                    n.sel = 1'b0;
                    n.st  = ST_RREL;
                end else if (!q.rvld) begin
                    n.ck = 1'b0;
                    n.st = ST_RLO;
                end
            end
            ST_RLO: begin
                n.ck = 1'b1;
                n.st = ST_RSMP;
            end
            ST_RSMP: begin
                n.rdat  = cfg_rdata;
                n.rvld  = 1'b1;
                rem_dec = 1'b1;
                n.st    = ST_RCHK;
            end
            ST_RREL: begin
                n.ck = 1'b0;
                n.st = ST_RPHI;
            end
            ST_RPHI: begin
                n.ck = 1'b1;
                n.st = ST_RFIN;
            end
            ST_RFIN: begin
                n.ck = 1'b0;
                n.st = ST_IDLE;
            end
            default: n.st = ST_IDLE;
        endcase
        if (expired) begin
            n.pgm   = 1'b0;
            n.sel   = 1'b0;
            n.wen   = 1'b0;
            n.ck    = 1'b0;
            n.tmo   = 1'b1;
            n.st    = ST_IDLE;
            rem_dec = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign cfg_reset_o = q.pgm;
    assign sel_o       = q.sel;
    assign wen_o       = q.wen;
    assign cfg_clk_o   = q.ck;
    assign cfg_wdata   = q.wdat;
    assign out_data    = q.rdat;
    assign out_valid   = q.rvld;
    assign timeout_o   = q.tmo;
    assign idle_o      = (q.st == ST_IDLE);

    AST_WEN_BEFORE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_o) && !q.rd |-> wen_o)                              // R3
        else $error("select raised without write enable");

    AST_TAKE_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> cfg_clk_o && sel_o && wen_o)                     // R4
        else $error("byte taken while clock low or link closed");

    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(cfg_wdata))               // R5
        else $error("outgoing byte changed without a handshake");

    AST_SEL_THEN_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wen_o) && !timeout_o |-> !sel_o && $past(!sel_o))       // R6
        else $error("write enable released before select");

    AST_TMO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> !cfg_reset_o && !sel_o && !wen_o && !cfg_clk_o) // R8
        else $error("timeout left a control line active");

    AST_RB_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_o) && q.rd |-> cfg_clk_o && !wen_o)                 // R9
        else $error("readback opened with wrong line levels");

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data))   // R11
        else $error("readback byte dropped under backpressure");
endmodule

// File: tb/pconf_master_test.sv
module pconf_master_test;
    localparam int CNT_W = 8;
    localparam int TMO   = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, mode_rd = 1'b0;
    logic [CNT_W-1:0] byte_count = '0;
    logic [7:0] in_data = '0;
    logic in_valid = 1'b0, in_ready;
    logic [7:0] out_data;
    logic out_valid, out_ready = 1'b1;
    logic cfg_reset_o, sel_o, wen_o, cfg_clk_o;
    logic [7:0] cfg_wdata, cfg_rdata = '0;
    logic tgt_initing_i = 1'b1, tgt_stall_i = 1'b0, tgt_ready_i = 1'b0;
    logic idle_o, timeout_o;

    always #4 clk = ~clk;

    pconf_master #(.CNT_W(CNT_W), .TMO_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_rd(mode_rd),
        .byte_count(byte_count), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .cfg_reset_o(cfg_reset_o), .sel_o(sel_o),
        .wen_o(wen_o), .cfg_clk_o(cfg_clk_o), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tgt_initing_i(tgt_initing_i),
        .tgt_stall_i(tgt_stall_i), .tgt_ready_i(tgt_ready_i),
        .idle_o(idle_o), .timeout_o(timeout_o)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;
    logic [7:0] lq[$];
    logic [7:0] rq[$];

    // target model and monitor state
    bit rd_mode = 0, armed = 0, stalled = 0, rb_bad = 0, rdy_always = 1;
    int ld_idx = 0, stall_idx = -1, stall_n = 0, stall_left = 0, stalls = 0;
    int rb_idx = 0, tail = 0, dn = 0, done_after = 0;
    int t_pgm_r, t_pgm_f, t_wen_r, t_wen_f, t_sel_r, t_sel_f, t_ck_r, t_init;
    logic p_ck = 0, p_sel = 0, p_wen = 0, p_pgm = 0, pv = 0, pr = 0;
    logic [7:0] pd = '0, held = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rb_pat(input int i);
        return 8'h3C ^ 8'(i * 17);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 60000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 60000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // monitor: plays the target and scores both streams
    always @(negedge clk) if (rst_n) begin
        logic rise;
        logic [7:0] e;
        rise = cfg_clk_o && !p_ck;
        if (cfg_reset_o && !p_pgm) t_pgm_r = cyc;
        if (!cfg_reset_o && p_pgm) t_pgm_f = cyc;
        if (wen_o && !p_wen) t_wen_r = cyc;
        if (!wen_o && p_wen) t_wen_f = cyc;
        if (sel_o && !p_sel) begin t_sel_r = cyc; armed = 0; end
        if (!sel_o && p_sel) t_sel_f = cyc;
        if (rd_mode && (wen_o || cfg_reset_o)) rb_bad = 1;
        if (rise) begin
            if (sel_o && !armed) begin
                armed = 1;
                t_ck_r = cyc;
            end else if (sel_o && wen_o) begin
                if (!stalled) stall_left = (ld_idx == stall_idx) ? stall_n : 0;
                if (stalled)
                    check(cfg_wdata == held, "R5", "byte kept over stall", cfg_wdata, held);
                if (stall_left > 0) begin
                    held = cfg_wdata;
                    stalled = 1;
                    stall_left--;
                    stalls++;
                    tgt_stall_i = 1'b1;
                end else begin
                    stalled = 0;
                    tgt_stall_i = 1'b0;
                    if (lq.size() == 0) check(0, "R4", "unexpected load byte", cfg_wdata, 0);
                    else begin
                        e = lq.pop_front();
                        check(cfg_wdata == e, "R4", "load byte at target", cfg_wdata, e);
                    end
                    ld_idx++;
                end
            end else if (sel_o && rd_mode) begin
                cfg_rdata = rb_pat(rb_idx);
                rb_idx++;
            end else if (!sel_o) begin
                if (rd_mode) tail++;
                else begin
                    dn++;
                    if (dn == done_after) tgt_ready_i = 1'b1;
                end
            end
        end
        if (pv && pr) begin
            if (rq.size() == 0) check(0, "R10", "unexpected readback byte", pd, 0);
            else begin
                e = rq.pop_front();
                check(pd == e, "R10", "readback byte", pd, e);
            end
        end
        if (pv && !pr) begin
            check(out_valid && out_data == pd, "R11", "held readback byte", out_data, pd);
            check(!(cfg_clk_o && !p_ck && sel_o), "R11", "no clock pulse while pending", 1, 0);
        end
        out_ready = rdy_always ? 1'b1 : ($urandom % 3 != 0);
        pv = out_valid; pr = out_ready; pd = out_data;
        p_ck = cfg_clk_o; p_sel = sel_o; p_wen = wen_o; p_pgm = cfg_reset_o;
    end

    task automatic wait_idle(input int limit);
        int k = 0;
        while (!idle_o && k < limit) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic run_load(input int n, input int sidx, input int sn, input int hold,
                            input int dafter, input int gap, input logic [7:0] seed,
                            input bit exp_tmo);
        rd_mode = 0; tgt_ready_i = 1'b0; tgt_initing_i = 1'b1; tgt_stall_i = 1'b0;
        dn = 0; done_after = dafter; ld_idx = 0; stall_idx = sidx; stall_n = sn;
        stalled = 0; stalls = 0;
        for (int i = 0; i < n; i++) lq.push_back(seed + 8'(i * 29));
        @(negedge clk);
        start = 1'b1; mode_rd = 1'b0; byte_count = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
        check(timeout_o == 1'b0, "R8", "flag cleared by start", timeout_o, 0);
        repeat (hold) @(negedge clk);
        tgt_initing_i = 1'b0;
        t_init = cyc;
        for (int i = 0; i < n; i++) begin
            in_data = seed + 8'(i * 29);
            in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
        wait_idle(2000);
        check(idle_o == 1'b1, "R7", "back to idle", idle_o, 1);
        check(lq.size() == 0 && ld_idx == n, "R4", "bytes delivered", ld_idx, n);
        check(t_pgm_f - t_pgm_r == 1, "R2", "reset pulse length", t_pgm_f - t_pgm_r, 1);
        check(t_wen_r > t_init, "R2", "write enable after init clear", t_wen_r, t_init + 1);
        check(t_sel_r == t_wen_r + 1, "R3", "select one cycle after write enable", t_sel_r, t_wen_r + 1);
        check(t_ck_r == t_sel_r + 1, "R3", "clock high one cycle after select", t_ck_r, t_sel_r + 1);
        check(t_wen_f == t_sel_f + 1, "R6", "write enable drops after select", t_wen_f, t_sel_f + 1);
        if (sidx >= 0 && sidx < n)
            check(stalls == sn, "R5", "stall pulses", stalls, sn);
        if (exp_tmo) begin
            check(timeout_o == 1'b1, "R8", "completion timeout flag", timeout_o, 1);
            check(!cfg_clk_o && !sel_o && !wen_o && !cfg_reset_o, "R8", "lines dropped", cfg_clk_o, 0);
        end else begin
            check(dn == dafter, "R7", "clock pulses until complete", dn, dafter);
            check(timeout_o == 1'b0 && cfg_clk_o == 1'b0, "R7", "clean finish", timeout_o, 0);
        end
    endtask

    task automatic run_rb(input int n, input bit always_rdy);
        int k;
        rd_mode = 1; rb_idx = 0; tail = 0; rb_bad = 0; rdy_always = always_rdy;
        for (int i = 0; i < n; i++) rq.push_back(rb_pat(i));
        @(negedge clk);
        start = 1'b1; mode_rd = 1'b1; byte_count = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
        check(sel_o && cfg_clk_o && !wen_o, "R9", "readback opening levels", {sel_o, cfg_clk_o, wen_o}, 3'b110);
        k = 0;
        while ((!idle_o || out_valid) && k < 3000) begin
            @(negedge clk);
            k++;
        end
        repeat (2) @(negedge clk);
        check(rq.size() == 0 && rb_idx == n, "R10", "readback bytes produced", rb_idx, n);
        check(tail == 1, "R12", "pulses after select drop", tail, 1);
        check(rb_bad == 0, "R9", "no write or reset during readback", rb_bad, 0);
        check(!sel_o && idle_o, "R12", "readback closed", sel_o, 0);
        rd_mode = 0; rdy_always = 1;
    endtask

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        check(!cfg_reset_o && !sel_o && !wen_o && !cfg_clk_o, "R1", "lines in reset",
              {cfg_reset_o, sel_o, wen_o, cfg_clk_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(idle_o == 1'b1 && timeout_o == 1'b0, "R1", "idle after reset", idle_o, 1);

        run_load(4, -1, 0, 5, 3, 0, 8'hA1, 0);
        run_load(5, 1, 2, 2, 1, 3, 8'h17, 0);
        run_load(3, 0, 4, 8, 6, 1, 8'h5E, 0);

        // initialisation never clears
        tgt_initing_i = 1'b1;
        @(negedge clk);
        start = 1'b1; mode_rd = 1'b0; byte_count = 2;
        c0 = cyc;
        @(negedge clk);
        start = 1'b0;
        wait_idle(1000);
        check(timeout_o == 1'b1, "R8", "init timeout flag", timeout_o, 1);
        check(cyc - c0 >= TMO && cyc - c0 <= TMO + 6, "R8", "init timeout length", cyc - c0, TMO + 2);
        check(!cfg_clk_o && !sel_o && !wen_o && !cfg_reset_o, "R8", "lines dropped", sel_o, 0);
        repeat (4) @(negedge clk);
        check(timeout_o == 1'b1, "R8", "flag is sticky", timeout_o, 1);

        // completion never reported
        run_load(2, -1, 0, 1, 0, 0, 8'hC3, 1);
        run_load(2, -1, 0, 1, 2, 0, 8'h08, 0);

        run_rb(6, 1);
        run_rb(9, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule